// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero-Bit Insertion

This block converts payload bytes into a synchronous serial frame on one line. Bytes arrive on a byte-wide ready/valid port together with an end-of-frame marker. The block puts the frame on the line one bit per transmit strobe, in this order: an opening 0x7E flag, the payload with zero-bit insertion, a 16-bit frame check sequence, and then a closing flag. When no frame is pending, the line carries back-to-back flags.

The transmit strobe (`bit_en`) is a clock enable that logic outside the block produces. That logic also chooses between an internal and an external bit clock, so the block only sees a one-cycle pulse per bit time.

Zero insertion ignores byte boundaries and also covers the check sequence. The number of line bits per byte therefore varies, and byte acceptance stalls whenever an inserted zero is due.

The transmitter has no state shared with a receive path, so it can run at the same time as an independent receiver.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst` is high, and on the clock after it falls, `tx_bit` is 1 and `in_ready` is 0. A synchronous reset in the middle of a frame abandons that frame, clears the ones-run count, and restarts idle flags from the first flag bit.
- R2: With no frame pending, the line carries the octet 0x7E over and over, least-significant bit first. The line bit order is therefore 0,1,1,1,1,1,1,0.
- R3: A frame starts when `in_valid` is high on the strobe that emits the last bit of an idle flag. That flag becomes the opening flag, and the next line bit is bit 0 of the first payload byte.
- R4: Payload bytes go out least-significant bit first. `in_ready` is high only in a strobe cycle whose line bit is bit 0 of a new byte. That line bit equals `in_data[0]`.
- R5: After five consecutive one bits, a zero bit is inserted. This holds across byte boundaries, inside the check sequence, and between the check sequence and the closing flag.
- R6: Flag bits are never subject to insertion, and every flag bit clears the ones-run count. A payload byte of 0x7E is therefore sent with one inserted zero.
- R7: The check sequence is CRC-16 with generator x^16 + x^12 + x^5 + 1, run bit-reflected (0x8408) over the payload bits in line order. It is preset to 0xFFFF at the start of every frame and sent ones-complemented, low-order bit first. For the ASCII payload "123456789" it is 0x906E.
- R8: The closing 0x7E flag follows the last check-sequence bit (or an inserted zero after it) directly. At least one more flag goes out before the next frame's payload.
- R9: The byte accepted with `in_last` high is the final payload byte. The check sequence starts on the next strobe after that byte's bit 7 (or after an inserted zero).
- R10: If `in_valid` is low when the first bit of a new payload byte is due, the frame ends there. That strobe emits the first check-sequence bit, computed over the bytes already sent.
- R11: `in_ready` stays low while an inserted zero, a flag bit or a check-sequence bit is emitted. Exactly one handshake happens per payload byte.
- R12: `tx_bit` and all framing state change only on clocks where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle pulse per transmit bit time |
| in_valid | input | 1 | Payload byte present |
| in_data | input | DATA_W | Payload byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Byte taken in this cycle (only with `bit_en`) |
| tx_bit | output | 1 | Serial line output, registered |

## Verification
The interaction that matters most is an inserted zero falling due on the exact strobe where the first bit of the next payload byte would go out. The run counter must win. `in_ready` then stays low for that strobe, and the handshake moves one bit later. This is provoked by payloads whose run of ones straddles a byte boundary (0xF0 followed by 0x1F, and 0xAA followed by 0x0F), and by a 0x7E payload byte. The result is judged by matching the whole captured line stream against an independently built stuffed stream, by counting exactly one handshake per byte, and by checking that each handshake's line bit equals the offered bit 0. Strobe spacings of one, two, three and seven clocks exercise the stall between strobes.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_CLOSE = 2'd3
  } tx_state_e;

  localparam int unsigned FLAG_W = 8;
  localparam logic [FLAG_W-1:0] FLAG_OCTET = 8'h7E;
  localparam int unsigned CRC_W = 16;

  // one bit of a reflected CRC: feedback from bit 0, shift toward LSB
  function automatic logic [CRC_W-1:0] crc_absorb(input logic [CRC_W-1:0] crc,
                                                  input logic              b,
                                                  input logic [CRC_W-1:0] poly_rev);
    logic fb;
    fb = crc[0] ^ b;
    crc_absorb = (crc >> 1) ^ (fb ? poly_rev : '0);
  endfunction

  // emptying the register toward the line: plain shift
  function automatic logic [CRC_W-1:0] crc_drain(input logic [CRC_W-1:0] crc);
    crc_drain = crc >> 1;
  endfunction

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
  import hdlc_tx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_REV = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET   = 16'hFFFF
) (
  input  logic clk,
  input  logic rst,
  input  logic seed,
  input  logic absorb,
  input  logic drain,
  input  logic bit_in,
  output logic fcs_bit
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst)         crc_q <= PRESET;
    else if (seed)   crc_q <= PRESET;
    else if (absorb) crc_q <= crc_absorb(crc_q, bit_in, POLY_REV);
    else if (drain)  crc_q <= crc_drain(crc_q);
  end

  // line carries the complement, low-order bit first
  assign fcs_bit = ~crc_q[0];

  p_seed_preset_r7: assert property (@(posedge clk) disable iff (rst)
    seed |=> (crc_q == PRESET));

  p_fcs_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(seed || absorb || drain) |=> $stable(crc_q));

  p_single_op_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({seed, absorb, drain}) <= 1);

endmodule

// File: rtl/hdlc_run_counter.sv
module hdlc_run_counter #(
  parameter int unsigned RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic clear,
  input  logic bit_in,
  output logic stuff_req
);

  localparam int unsigned CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (step) begin
      if (clear || !bit_in)  cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stuff_req = (cnt_q == CW'(RUN));

  p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(RUN));

  p_stuff_forces_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (step && stuff_req) |-> (!bit_in && !clear));

  p_flag_clears_run_r6: assert property (@(posedge clk) disable iff (rst)
    (step && clear) |=> (cnt_q == '0));

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              stuff_req,
  input  logic              fcs_bit,
  output logic              in_ready,
  output logic              line_next,
  output logic              run_clear,
  output logic              fcs_seed,
  output logic              fcs_absorb,
  output logic              fcs_drain
);

  localparam int unsigned BW = $clog2(DATA_W);
  localparam int unsigned FW = $clog2(FLAG_W);
  localparam int unsigned CW = $clog2(CRC_W);

  tx_state_e         state_q, state_d;
  logic [FW-1:0]     fidx_q, fidx_d;
  logic [BW-1:0]     bidx_q, bidx_d;
  logic [CW-1:0]     cidx_q, cidx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              last_q, last_d;

  logic take_c, seed_c, absorb_c, drain_c;

  always_comb begin
    state_d   = state_q;
    fidx_d    = fidx_q;
    bidx_d    = bidx_q;
    cidx_d    = cidx_q;
    sh_d      = sh_q;
    last_d    = last_q;
    line_next = 1'b1;
    take_c    = 1'b0;
    run_clear = 1'b0;
    seed_c    = 1'b0;
    absorb_c  = 1'b0;
    drain_c   = 1'b0;
    if (stuff_req) begin
      line_next = 1'b0;           // inserted zero; nothing advances
    end else begin
      case (state_q)
        ST_FLAG, ST_CLOSE: begin
          line_next = FLAG_OCTET[fidx_q];
          run_clear = 1'b1;
          fidx_d    = fidx_q + 1'b1;
          if (fidx_q == FW'(FLAG_W - 1)) begin
            if (state_q == ST_CLOSE) begin
              state_d = ST_FLAG;
            end else if (in_valid) begin
              state_d = ST_DATA;
              bidx_d  = '0;
              seed_c  = 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (bidx_q == '0) begin
            if (in_valid) begin
              take_c    = 1'b1;
              line_next = in_data[0];
              sh_d      = in_data;
              last_d    = in_last;
              absorb_c  = 1'b1;
              bidx_d    = BW'(1);
            end else begin
              // underrun: the check sequence starts in this bit
              line_next = fcs_bit;
              drain_c   = 1'b1;
              cidx_d    = CW'(1);
              state_d   = ST_FCS;
            end
          end else begin
            line_next = sh_q[bidx_q];
            absorb_c  = 1'b1;
            bidx_d    = bidx_q + 1'b1;
            if (bidx_q == BW'(DATA_W - 1)) begin
              bidx_d = '0;
              if (last_q) begin
                state_d = ST_FCS;
                cidx_d  = '0;
              end
            end
          end
        end
        ST_FCS: begin
          line_next = fcs_bit;
          drain_c   = 1'b1;
          cidx_d    = cidx_q + 1'b1;
          if (cidx_q == CW'(CRC_W - 1)) begin
            state_d = ST_CLOSE;
            fidx_d  = '0;
          end
        end
        default: state_d = ST_FLAG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FLAG;
      fidx_q  <= '0;
      bidx_q  <= '0;
      cidx_q  <= '0;
      sh_q    <= '0;
      last_q  <= 1'b0;
    end else if (bit_en) begin
      state_q <= state_d;
      fidx_q  <= fidx_d;
      bidx_q  <= bidx_d;
      cidx_q  <= cidx_d;
      sh_q    <= sh_d;
      last_q  <= last_d;
    end
  end

  assign in_ready   = bit_en && take_c;
  assign fcs_seed   = bit_en && seed_c;
  assign fcs_absorb = bit_en && absorb_c;
  assign fcs_drain  = bit_en && drain_c;

  p_reset_to_idle_r1: assert property (@(posedge clk)
    rst |=> (state_q == ST_FLAG && fidx_q == '0));

  p_ready_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> bit_en);

  p_ready_data_only_r11: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (state_q == ST_DATA && !stuff_req));

  p_fcs_then_close_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !stuff_req && state_q == ST_FCS && cidx_q == CW'(CRC_W - 1))
      |=> (state_q == ST_CLOSE));

  p_underrun_to_fcs_r10: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !stuff_req && state_q == ST_DATA && bidx_q == '0 && !in_valid)
      |=> (state_q == ST_FCS));

  p_state_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(state_q));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned      DATA_W    = 8,
  parameter int unsigned      STUFF_RUN = 5,
  parameter logic [CRC_W-1:0] POLY_REV  = 16'h8408
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit
);

  // internal events brought out by name
  logic stuff_req;
  logic line_next;
  logic run_clear;
  logic fcs_seed, fcs_absorb, fcs_drain;
  logic fcs_bit;
  logic tx_q;

  hdlc_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .stuff_req  (stuff_req),
    .fcs_bit    (fcs_bit),
    .in_ready   (in_ready),
    .line_next  (line_next),
    .run_clear  (run_clear),
    .fcs_seed   (fcs_seed),
    .fcs_absorb (fcs_absorb),
    .fcs_drain  (fcs_drain)
  );

  hdlc_run_counter #(.RUN(STUFF_RUN)) u_run (
    .clk       (clk),
    .rst       (rst),
    .step      (bit_en),
    .clear     (run_clear),
    .bit_in    (line_next),
    .stuff_req (stuff_req)
  );

  hdlc_fcs_gen #(.POLY_REV(POLY_REV), .PRESET('1)) u_fcs (
    .clk     (clk),
    .rst     (rst),
    .seed    (fcs_seed),
    .absorb  (fcs_absorb),
    .drain   (fcs_drain),
    .bit_in  (line_next),
    .fcs_bit (fcs_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)         tx_q <= 1'b1;
    else if (bit_en) tx_q <= line_next;
  end

  assign tx_bit = tx_q;

  p_stuff_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && stuff_req) |=> !tx_bit);

  p_line_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit));

  p_ready_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (tx_bit == $past(in_data[0])));

endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;

  localparam int NV = 6;
  localparam int ML = 9;
  localparam logic [7:0] VDATA [0:NV*ML-1] = '{
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h7E, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'hF0, 8'h1F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39,
    8'h55, 8'hAA, 8'h0F, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00
  };
  localparam int VLEN [0:NV-1] = '{1, 1, 2, 3, 9, 4};
  localparam int VDIV [0:NV-1] = '{1, 2, 3, 2, 1, 7};
  localparam int VSTF [0:NV-1] = '{0, 1, 1, 4, 0, 1}; // zeros inserted inside payload
  localparam logic [7:0] FLAG = 8'h7E;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  wire in_ready, tx_bit;

  always #5 clk = ~clk;

  hdlc_tx_framer uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .tx_bit(tx_bit)
  );

  int checks = 0, errors = 0;
  int div = 0, divcnt = 0;
  logic line_log [0:16383];
  int nlog = 0, r4_bad = 0, r12_bad = 0, hs_count = 0;
  logic [7:0] cur [0:15];
  logic exp_b [0:2047];
  int exp_n = 0, run = 0, stuffs = 0, pay_stuffs = 0;
  logic m_en, m_hs, m_d0, m_prev;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // strobe generator: one pulse every div clocks, off when div is 0
  always @(negedge clk) begin
    if (div == 0) begin
      bit_en = 1'b0; divcnt = 0;
    end else if (divcnt >= div - 1) begin
      bit_en = 1'b1; divcnt = 0;
    end else begin
      bit_en = 1'b0; divcnt++;
    end
  end

  // line monitor: inputs read at the edge, line read shortly after
  always @(posedge clk) begin
    if (!rst) begin
      m_en = bit_en; m_hs = in_valid && in_ready; m_d0 = in_data[0]; m_prev = tx_bit;
      #3;
      if (m_en) begin
        if (nlog < 16384) begin line_log[nlog] = tx_bit; nlog++; end
        if (m_hs && tx_bit !== m_d0) r4_bad++;
      end else if (tx_bit !== m_prev) r12_bad++;
      if (m_hs) hs_count++;
    end
  end

  function automatic logic [15:0] fcs_of(input int len);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {8'h00, cur[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push_raw(input logic b);
    exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic push_st(input logic b);
    push_raw(b);
    run = b ? run + 1 : 0;
    if (run == 5) begin push_raw(1'b0); run = 0; stuffs++; end
  endtask

  task automatic build(input int len);
    logic [15:0] f;
    exp_n = 0; run = 0; stuffs = 0;
    for (int i = 0; i < 8; i++) push_raw(FLAG[i]);
    for (int i = 0; i < len; i++)
      for (int k = 0; k < 8; k++) push_st(cur[i][k]);
    pay_stuffs = stuffs;
    f = fcs_of(len);
    for (int i = 0; i < 16; i++) push_st(f[i]);
    for (int i = 0; i < 16; i++) push_raw(FLAG[i % 8]);
  endtask

  function automatic int find_stream(input int from);
    for (int s = from; s + exp_n <= nlog; s++) begin
      bit hit;
      hit = 1'b1;
      for (int i = 0; i < exp_n; i++) if (line_log[s+i] !== exp_b[i]) hit = 1'b0;
      if (hit) return s;
    end
    return -1;
  endfunction

  task automatic wait_bits(input int k);
    int t;
    t = nlog + k;
    while (nlog < t) @(negedge clk);
  endtask

  task automatic send(input int len, input bit mark_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = cur[i]; in_last = mark_last && (i == len - 1);
      @(posedge clk);
      while (!in_ready) @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic check_flags(input int mark, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 16; i++) if (line_log[mark+i] !== FLAG[i % 8]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic frame_test(input int len, input bit mark_last, input string tag);
    int mark, idx;
    wait_bits(3);
    mark = nlog; hs_count = 0;
    send(len, mark_last);
    wait_bits(64);
    build(len);
    idx = find_stream(mark > 8 ? mark - 8 : 0);
    check(idx >= 0, tag, idx, mark);
    check(hs_count == len, {tag, " R11 one handshake per byte"}, hs_count, len);
  endtask

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mark;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state before any strobe
    check(tx_bit === 1'b1, "R1 tx_bit after reset", tx_bit, 1);
    check(in_ready === 1'b0, "R1 in_ready after reset", in_ready, 0);
    // R2: idle flags
    div = 2;
    mark = nlog;
    wait_bits(16);
    check_flags(mark, "R2 idle flag pattern");
    // R7: model anchor on the standard check string
    for (int i = 0; i < ML; i++) cur[i] = VDATA[4*ML+i];
    check(fcs_of(9) == 16'h906E, "R7 fcs of 123456789", fcs_of(9), 16'h906E);

    // vector table: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      div = VDIV[v];
      for (int i = 0; i < ML; i++) cur[i] = VDATA[v*ML+i];
      frame_test(VLEN[v], 1'b1, $sformatf("R3 R5 R6 R7 R8 R9 frame stream v%0d", v));
      check(pay_stuffs == VSTF[v], $sformatf("R5 R6 payload insert count v%0d", v),
            pay_stuffs, VSTF[v]);
    end

    // R10: underrun ends the frame
    div = 2;
    cur[0] = 8'hAB; cur[1] = 8'hCD;
    frame_test(2, 1'b0, "R10 underrun closes frame");

    // R1: reset in the middle of a frame
    div = 3;
    @(negedge clk); in_valid = 1'b1; in_data = 8'hFF; in_last = 1'b0;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    wait_bits(4);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(tx_bit === 1'b1, "R1 tx_bit after mid-frame reset", tx_bit, 1);
    check(in_ready === 1'b0, "R1 in_ready after mid-frame reset", in_ready, 0);
    mark = nlog;
    wait_bits(16);
    check_flags(mark, "R1 flags restart after mid-frame reset");
    cur[0] = 8'hFF; cur[1] = 8'hFF;
    frame_test(2, 1'b1, "R1 R5 clean frame after reset");

    check(r4_bad == 0, "R4 handshake line bit equals in_data[0]", r4_bad, 0);
    check(r12_bad == 0, "R12 line holds between strobes", r12_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule